// File: doc/BRIEF.md
# Two-Dimensional DMA Address Sequencer

This block produces the source and destination byte addresses for one DMA channel. The channel moves a block made of frames, and each frame holds a fixed number of elements. A load pulse captures the following values:
- both start addresses,
- the element and frame counts,
- the element size in bytes,
- an addressing mode for each side,
- signed element and frame index values for each side.

From these values the block works out two steps for each side. One step is added after every element. The other is an extra step added when a frame is finished.

After a valid load, the block drives the address pair of the next element. Each element strobe consumes that pair and moves to the next one. The sequencer raises one-cycle event pulses for half-frame, end-of-frame, last-frame and end-of-block. When the block ends it returns to idle. Memory access and arbitration belong to the surrounding channel logic.

Top module: `dma2d_addr_gen`

## Requirements
- R1: After reset `busy`, `load_err`, both address outputs and all four event pulses are 0.
- R2: A load with nonzero element and frame counts sets `busy` one cycle later. In that same cycle `cur_src`/`cur_dst` show the start addresses and all counters are cleared. A load takes priority over a strobe in the same cycle.
- R3: A load with a zero element count or a zero frame count is rejected. One cycle later `load_err` pulses high for one cycle and `busy` is 0.
- R4: Mode 0 (constant) uses an element step of 0 and a frame step of 0.
- R5: Mode 1 (post-increment) uses an element step equal to the element size in bytes and a frame step of 0.
- R6: Mode 2 (single index) uses an element step of size + element_index − 1 and a frame step of 0.
- R7: Mode 3 (double index) uses the same element step as mode 2. At a frame boundary it also adds frame_index − element_index.
- R8: With `legacy` high, both sides take the source-side element and frame index. With `legacy` low, each side uses its own index values.
- R9: Each strobe while busy increments the element counter, and the addresses change one cycle after the strobe. When the counter equals the element count, the following happens:
  - the counter returns to 0,
  - the frame step is added,
  - the frame counter increments,
  - `frame_end` pulses one cycle after the strobe.
- R10: `half_frame` pulses one cycle after the strobe that brings the element counter to element_count/2, rounded down.
- R11: `last_frame` pulses one cycle after the strobe that brings the element counter to 1 while the frame counter equals frame_count − 1.
- R12: When the frame counter reaches the frame count, `block_end` pulses together with `frame_end` and `busy` falls. Strobes while idle change nothing.
- R13: Addresses wrap modulo 2^32.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| load | input | 1 | Capture a new transfer description |
| src_start | input | 32 | Source start address |
| dst_start | input | 32 | Destination start address |
| elem_count | input | 16 | Elements per frame |
| frame_count | input | 16 | Frames per block |
| elem_size | input | 3 | Element size in bytes (1, 2 or 4) |
| src_mode | input | 2 | Source addressing mode (0..3) |
| dst_mode | input | 2 | Destination addressing mode (0..3) |
| legacy | input | 1 | Both sides use the source index values |
| src_eidx | input | 16 | Source element index, signed |
| src_fidx | input | 16 | Source frame index, signed |
| dst_eidx | input | 16 | Destination element index, signed |
| dst_fidx | input | 16 | Destination frame index, signed |
| step | input | 1 | Element strobe: consume the current address pair |
| busy | output | 1 | A block is in progress |
| load_err | output | 1 | One-cycle pulse after a rejected load |
| cur_src | output | 32 | Source address of the next element |
| cur_dst | output | 32 | Destination address of the next element |
| half_frame | output | 1 | Half-frame event pulse |
| frame_end | output | 1 | End-of-frame event pulse |
| last_frame | output | 1 | Last-frame event pulse |
| block_end | output | 1 | End-of-block event pulse |

## Verification
The properties assume that the description inputs matter only in the cycle `load` is high. They also assume that a strobe while idle is legal input that must leave the addresses untouched. The bench changes the description inputs freely between loads to make sure nothing is taken from them later. It drives strobes both with gaps and back-to-back, and it keeps issuing them after a block ends. Element sizes are kept to 1, 2 and 4 bytes, and counts are small, so every block finishes within a few dozen cycles.

// File: rtl/dma2d_pkg.sv
package dma2d_pkg;
    typedef enum logic [1:0] {
        AM_FIXED  = 2'd0,
        AM_INCR   = 2'd1,
        AM_SINDEX = 2'd2,
        AM_DINDEX = 2'd3
    } addr_mode_e;

    localparam int ADDR_W = 32;
    localparam int IDX_W  = 16;
endpackage

// File: rtl/dma2d_step_calc.sv
module dma2d_step_calc
    import dma2d_pkg::*;
#(
    parameter int AW = ADDR_W,
    parameter int IW = IDX_W,
    parameter int SW = 3
) (
    input  logic [1:0]           mode,
    input  logic [SW-1:0]        size,
    input  logic signed [IW-1:0] eidx,
    input  logic signed [IW-1:0] fidx,
    output logic signed [AW-1:0] elem_delta,
    output logic signed [AW-1:0] frame_delta
);
    logic signed [AW-1:0] sz_x, ei_x, fi_x;

    always_comb begin
        sz_x = {{(AW-SW){1'b0}}, size};
        ei_x = {{(AW-IW){eidx[IW-1]}}, eidx};
        fi_x = {{(AW-IW){fidx[IW-1]}}, fidx};
        elem_delta  = '0;
        frame_delta = '0;
        case (addr_mode_e'(mode))
            AM_FIXED:  ;
            AM_INCR:   elem_delta = sz_x;
            AM_SINDEX: elem_delta = sz_x + ei_x - 1;
            AM_DINDEX: begin
                elem_delta  = sz_x + ei_x - 1;
                frame_delta = fi_x - ei_x;
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/dma2d_seq.sv
module dma2d_seq #(
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic          abort,
    input  logic          adv,
    input  logic [CW-1:0] ecount,
    input  logic [CW-1:0] fcount,
    output logic          busy,
    output logic          wrap,
    output logic          half_evt,
    output logic          fend_evt,
    output logic          last_evt,
    output logic          bend_evt
);
    typedef struct packed {
        logic [CW-1:0] elem;
        logic [CW-1:0] frame;
        logic [CW-1:0] ecnt;
        logic [CW-1:0] fcnt;
        logic          busy;
        logic          half;
        logic          fend;
        logic          last;
        logic          bend;
    } seq_t;

    seq_t s_d, s_q;
    logic [CW:0] ne, nf;

    always_comb begin
        s_d      = s_q;
        s_d.half = 1'b0;
        s_d.fend = 1'b0;
        s_d.last = 1'b0;
        s_d.bend = 1'b0;
        ne   = {1'b0, s_q.elem} + 1'b1;
        nf   = {1'b0, s_q.frame} + 1'b1;
        wrap = 1'b0;
        if (start) begin
            s_d.elem  = '0;
            s_d.frame = '0;
            s_d.ecnt  = ecount;
            s_d.fcnt  = fcount;
            s_d.busy  = 1'b1;
        end else if (abort) begin
            s_d.busy = 1'b0;
        end else if (adv && s_q.busy) begin
            s_d.half = (ne == {2'b0, s_q.ecnt[CW-1:1]});
            s_d.last = (ne == 1) && ({1'b0, s_q.frame} == {1'b0, s_q.fcnt} - 1'b1);
            if (ne == {1'b0, s_q.ecnt}) begin
                wrap      = 1'b1;
                s_d.elem  = '0;
                s_d.frame = nf[CW-1:0];
                s_d.fend  = 1'b1;
                if (nf == {1'b0, s_q.fcnt}) begin
                    s_d.bend = 1'b1;
                    s_d.busy = 1'b0;
                end
            end else begin
                s_d.elem = ne[CW-1:0];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign busy     = s_q.busy;
    assign half_evt = s_q.half;
    assign fend_evt = s_q.fend;
    assign last_evt = s_q.last;
    assign bend_evt = s_q.bend;
endmodule

// File: rtl/dma2d_addr_gen.sv
module dma2d_addr_gen
    import dma2d_pkg::*;
#(
    parameter int CNT_W  = 16,
    parameter int SIZE_W = 3
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    load,
    input  logic [ADDR_W-1:0]       src_start,
    input  logic [ADDR_W-1:0]       dst_start,
    input  logic [CNT_W-1:0]        elem_count,
    input  logic [CNT_W-1:0]        frame_count,
    input  logic [SIZE_W-1:0]       elem_size,
    input  logic [1:0]              src_mode,
    input  logic [1:0]              dst_mode,
    input  logic                    legacy,
    input  logic signed [IDX_W-1:0] src_eidx,
    input  logic signed [IDX_W-1:0] src_fidx,
    input  logic signed [IDX_W-1:0] dst_eidx,
    input  logic signed [IDX_W-1:0] dst_fidx,
    input  logic                    step,
    output logic                    busy,
    output logic                    load_err,
    output logic [ADDR_W-1:0]       cur_src,
    output logic [ADDR_W-1:0]       cur_dst,
    output logic                    half_frame,
    output logic                    frame_end,
    output logic                    last_frame,
    output logic                    block_end
);
    localparam int SIDES = 2;

    typedef struct packed {
        logic [SIDES-1:0][ADDR_W-1:0] addr;
        logic [SIDES-1:0][ADDR_W-1:0] ed;
        logic [SIDES-1:0][ADDR_W-1:0] fd;
        logic                         err;
    } ag_t;

    ag_t a_d, a_q;

    logic                    bad_load, good_load, wrap;
    logic [SIDES-1:0][1:0]   mode_v;
    logic [SIDES-1:0][ADDR_W-1:0] start_v;
    logic signed [IDX_W-1:0] ei_v [SIDES];
    logic signed [IDX_W-1:0] fi_v [SIDES];
    logic signed [ADDR_W-1:0] ed_v [SIDES];
    logic signed [ADDR_W-1:0] fd_v [SIDES];

    assign bad_load  = load && (elem_count == '0 || frame_count == '0);
    assign good_load = load && !bad_load;

    assign mode_v[0]  = src_mode;
    assign mode_v[1]  = dst_mode;
    assign start_v[0] = src_start;
    assign start_v[1] = dst_start;
    assign ei_v[0]    = src_eidx;
    assign fi_v[0]    = src_fidx;
    assign ei_v[1]    = legacy ? src_eidx : dst_eidx;
    assign fi_v[1]    = legacy ? src_fidx : dst_fidx;

    for (genvar g = 0; g < SIDES; g++) begin : g_side
        dma2d_step_calc #(.AW(ADDR_W), .IW(IDX_W), .SW(SIZE_W)) u_calc (
            .mode        (mode_v[g]),
            .size        (elem_size),
            .eidx        (ei_v[g]),
            .fidx        (fi_v[g]),
            .elem_delta  (ed_v[g]),
            .frame_delta (fd_v[g])
        );
    end

    dma2d_seq #(.CW(CNT_W)) u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (good_load),
        .abort    (bad_load),
        .adv      (step),
        .ecount   (elem_count),
        .fcount   (frame_count),
        .busy     (busy),
        .wrap     (wrap),
        .half_evt (half_frame),
        .fend_evt (frame_end),
        .last_evt (last_frame),
        .bend_evt (block_end)
    );

    always_comb begin
        a_d     = a_q;
        a_d.err = bad_load;
        if (good_load) begin
            for (int i = 0; i < SIDES; i++) begin
                a_d.addr[i] = start_v[i];
                a_d.ed[i]   = ed_v[i];
                a_d.fd[i]   = fd_v[i];
            end
        end else if (!load && step && busy) begin
            for (int i = 0; i < SIDES; i++)
                a_d.addr[i] = a_q.addr[i] + a_q.ed[i] + (wrap ? a_q.fd[i] : '0);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) a_q <= '0;
        else        a_q <= a_d;
    end

    assign cur_src  = a_q.addr[0];
    assign cur_dst  = a_q.addr[1];
    assign load_err = a_q.err;
endmodule

// File: rtl/dma2d_addr_gen_chk.sv
module dma2d_addr_gen_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        load,
    input logic        step,
    input logic [31:0] src_start,
    input logic [15:0] elem_count,
    input logic [15:0] frame_count,
    input logic        busy,
    input logic        load_err,
    input logic [31:0] cur_src,
    input logic [31:0] cur_dst,
    input logic        half_frame,
    input logic        frame_end,
    input logic        last_frame,
    input logic        block_end
);
    assert_start_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (load && elem_count != 0 && frame_count != 0) |=> (busy && cur_src == $past(src_start)));

    assert_reject_R3: assert property (@(posedge clk) disable iff (!rst_n)
        load_err |-> !busy);

    assert_frame_with_block_R9: assert property (@(posedge clk) disable iff (!rst_n)
        block_end |-> frame_end);

    assert_evt_cause_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (half_frame || last_frame || frame_end) |-> $past(step && busy));

    assert_block_idle_R12: assert property (@(posedge clk) disable iff (!rst_n)
        block_end |-> !busy);

    assert_idle_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !load) |=> ($stable(cur_src) && $stable(cur_dst)));
endmodule

bind dma2d_addr_gen dma2d_addr_gen_chk u_chk (
    .clk(clk), .rst_n(rst_n), .load(load), .step(step), .src_start(src_start),
    .elem_count(elem_count), .frame_count(frame_count), .busy(busy),
    .load_err(load_err), .cur_src(cur_src), .cur_dst(cur_dst),
    .half_frame(half_frame), .frame_end(frame_end), .last_frame(last_frame),
    .block_end(block_end)
);

// File: tb/dma2d_addr_gen_test.sv
`timescale 1ns/1ps
module dma2d_addr_gen_test;
    logic clk = 0, rst_n = 0, load = 0, step = 0, legacy = 0;
    logic [31:0] src_start = 0, dst_start = 0;
    logic [15:0] elem_count = 0, frame_count = 0;
    logic [2:0]  elem_size = 0;
    logic [1:0]  src_mode = 0, dst_mode = 0;
    logic signed [15:0] src_eidx = 0, src_fidx = 0, dst_eidx = 0, dst_fidx = 0;
    logic busy, load_err, half_frame, frame_end, last_frame, block_end;
    logic [31:0] cur_src, cur_dst;

    int checks = 0, failures = 0, cycles = 0;
    string req = "R1";

    // behavioural reference
    bit [31:0] m_src, m_dst;
    int m_ed[2], m_fd[2], m_e, m_f, m_ec, m_fc;
    bit m_busy, m_err, m_half, m_fe, m_last, m_be;

    always #2 clk = ~clk;

    dma2d_addr_gen uut (.*);

    function automatic int elem_step(int mode, int sz, int ei);
        if (mode == 0) return 0;
        if (mode == 1) return sz;
        return sz + ei - 1;
    endfunction

    always @(posedge clk) begin
        cycles++;
        if (!rst_n) begin
            m_src = 0; m_dst = 0; m_busy = 0; m_err = 0;
            m_half = 0; m_fe = 0; m_last = 0; m_be = 0; m_e = 0; m_f = 0;
        end else begin
            m_err = 0; m_half = 0; m_fe = 0; m_last = 0; m_be = 0;
            if (load) begin
                if (elem_count == 0 || frame_count == 0) begin
                    m_err = 1; m_busy = 0;
                end else begin
                    int se, sf, de, df;
                    se = src_eidx; sf = src_fidx;
                    de = legacy ? se : int'(dst_eidx);
                    df = legacy ? sf : int'(dst_fidx);
                    m_src = src_start; m_dst = dst_start;
                    m_ed[0] = elem_step(src_mode, elem_size, se);
                    m_ed[1] = elem_step(dst_mode, elem_size, de);
                    m_fd[0] = (src_mode == 3) ? sf - se : 0;
                    m_fd[1] = (dst_mode == 3) ? df - de : 0;
                    m_e = 0; m_f = 0; m_ec = elem_count; m_fc = frame_count; m_busy = 1;
                end
            end else if (step && m_busy) begin
                m_src = m_src + 32'(m_ed[0]);
                m_dst = m_dst + 32'(m_ed[1]);
                m_e++;
                if (m_e == m_ec / 2) m_half = 1;
                if (m_e == 1 && m_f == m_fc - 1) m_last = 1;
                if (m_e == m_ec) begin
                    m_e = 0; m_f++; m_fe = 1;
                    m_src = m_src + 32'(m_fd[0]);
                    m_dst = m_dst + 32'(m_fd[1]);
                    if (m_f == m_fc) begin m_be = 1; m_busy = 0; end
                end
            end
        end
    end

    task automatic chk(string what, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic compare();
        chk("busy", 32'(busy), 32'(m_busy));
        chk("load_err", 32'(load_err), 32'(m_err));
        chk("cur_src", cur_src, m_src);
        chk("cur_dst", cur_dst, m_dst);
        chk("half_frame", 32'(half_frame), 32'(m_half));
        chk("frame_end", 32'(frame_end), 32'(m_fe));
        chk("last_frame", 32'(last_frame), 32'(m_last));
        chk("block_end", 32'(block_end), 32'(m_be));
    endtask

    task automatic tick(bit l, bit s);
        @(negedge clk);
        compare();
        load = l; step = s;
    endtask

    task automatic setup(bit [31:0] sa, bit [31:0] da, int ec, int fc, int sz,
                         int sm, int dm, bit lg, int sei, int sfi, int dei, int dfi);
        @(negedge clk);
        compare();
        src_start = sa; dst_start = da; elem_count = 16'(ec); frame_count = 16'(fc);
        elem_size = 3'(sz); src_mode = 2'(sm); dst_mode = 2'(dm); legacy = lg;
        src_eidx = 16'(sei); src_fidx = 16'(sfi); dst_eidx = 16'(dei); dst_fidx = 16'(dfi);
        load = 1; step = 0;
        tick(0, 0);
        // scramble the description inputs: nothing may be taken from them later
        src_start = 32'hDEAD_BEEF; elem_count = 16'd7; src_eidx = 16'sd99; dst_fidx = -16'sd50;
    endtask

    task automatic run(int n, bit gaps);
        for (int i = 0; i < n; i++) begin
            tick(0, 1);
            if (gaps && i % 3 == 1) tick(0, 0);
        end
        tick(0, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        req = "R1"; compare();
        rst_n = 1;

        req = "R5"; // post-increment, 4-byte elements, 4x2 block, also R9 R10 R11 R12
        setup(32'h1000, 32'h8000, 4, 2, 4, 1, 1, 0, 0, 0, 0, 0);
        run(8, 1);
        req = "R12"; run(3, 0); // idle strobes ignored

        req = "R4"; // constant source, single-index destination (R6)
        setup(32'h2000, 32'h3000, 3, 2, 2, 0, 2, 0, 0, 0, 3, 0);
        run(6, 0);

        req = "R7"; // double index per side, negative frame index
        setup(32'h4000, 32'h5000, 3, 3, 1, 3, 3, 0, 2, -6, 5, 10);
        run(9, 1);

        req = "R8"; // legacy: destination takes source indices
        setup(32'h6000, 32'h7000, 2, 3, 2, 3, 3, 1, 4, -8, 1, 40);
        run(6, 0);

        req = "R3"; // rejected loads
        setup(32'h1, 32'h2, 0, 3, 1, 1, 1, 0, 0, 0, 0, 0);
        run(2, 0);
        setup(32'h1, 32'h2, 3, 0, 1, 1, 1, 0, 0, 0, 0, 0);
        run(1, 0);

        req = "R13"; // address wrap
        setup(32'hFFFF_FFF8, 32'h0000_0004, 5, 1, 4, 1, 2, 0, 0, 0, -7, 0);
        run(5, 0);

        req = "R11"; // single element, single frame
        setup(32'hA0, 32'hB0, 1, 1, 1, 1, 1, 0, 0, 0, 0, 0);
        run(2, 0);

        req = "R2"; // reload mid-block; load wins over strobe
        setup(32'h100, 32'h200, 4, 4, 2, 1, 1, 0, 0, 0, 0, 0);
        run(3, 0);
        src_start = 32'h900; elem_count = 2; frame_count = 2; step = 1; load = 1;
        tick(0, 1); req = "R10"; run(4, 0);

        tick(0, 0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        wait (cycles > 20000);
        failures++;
        $display("FAIL watchdog actual=%0d expected<20000", cycles);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule